// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This unit keeps the pending, in-service and trigger-type state of a local interrupt controller as three flat bit vectors, one bit per vector number. Any number of sources may post vectors. Each posted vector carries a trigger type. The unit works out a processor priority from the task priority and from the most urgent vector now in service. It raises the processor interrupt line only when a pending vector belongs to a strictly more urgent priority class.

The processor talks to the unit through two strobes. An acknowledge strobe claims the most urgent pending vector. One cycle later the unit returns either that vector or the spurious vector. An end-of-interrupt strobe retires the most urgent vector in service. The task priority can be written at full width. It can also be written and read through a short port that carries only the priority class. A spurious-vector register holds the global enable bit and the vector returned when an acknowledge is refused.

Top module: `vec_prio_unit`

## Requirements
- R1: A higher vector number is more urgent. The acknowledge and the interrupt decision always use the highest-numbered pending vector. Vector 0 and vector 255 both work as vector numbers.
- R2: A posted vector sets its pending bit. It also records its trigger type: `req_level`=1 means level and 0 means edge. When the same vector is posted again, the newest type replaces the stored one. The stored type is returned on `ack_level` when the vector is granted.
- R3: `irq` stays low while bit 8 of the spurious-vector register is 0. This holds whatever requests are pending.
- R4: When enabled, `irq` is high only if a vector is pending and one of two conditions holds. Either the processor priority is zero, or the pending vector's class (bits [7:4]) is strictly greater than the processor-priority class.
- R5: The processor priority equals the task priority when the task-priority class is at least the class of the highest in-service vector. Otherwise it is that in-service vector with bits [3:0] cleared.
- R6: An acknowledge is refused when the task priority is nonzero and the top pending vector is less than or equal to it. A refused acknowledge returns bits [7:0] of the spurious-vector register with `ack_level`=0 and changes no state.
- R7: A granted acknowledge moves the top pending vector from pending to in-service. `ack_valid` is high in the cycle after the `ack` strobe, and `ack_vector` carries the vector in that cycle.
- R8: An acknowledge with nothing pending returns the spurious vector and changes nothing.
- R9: End-of-interrupt clears only the highest set in-service bit. It does nothing when no in-service bit is set.
- R10: A short task-priority write of value v stores v<<4. `tpr_short_rd` returns bits [7:4] of the task priority.
- R11: Reset clears the pending, in-service and trigger vectors and the task priority, and loads 0x0FF into the spurious-vector register. After reset `irq` is low and an acknowledge returns 0xFF.
- R12: An acknowledge uses the state from before its clock edge. A vector posted in the same cycle stays pending for a later acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming vector strobe |
| req_vector | input | 8 | Incoming vector number |
| req_level | input | 1 | Trigger type of incoming vector, 1 = level |
| tpr_wr | input | 1 | Full task-priority write strobe |
| tpr_wdata | input | 8 | Full task-priority value |
| tpr_short_wr | input | 1 | Short task-priority write strobe |
| tpr_short_wdata | input | 4 | Task-priority class value |
| tpr_short_rd | output | 4 | Task-priority class readback |
| svr_wr | input | 1 | Spurious-vector register write strobe |
| svr_wdata | input | 9 | Bit 8 enable, bits [7:0] spurious vector |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Processor interrupt line |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Granted or spurious vector |
| ack_level | output | 1 | Trigger type of the granted vector |

## Verification
The bench builds the unit with its default 8-bit vector number and 4-bit class offset. That puts vectors 0 and 255 in reach, together with class-equality thresholds such as 0x47 against priority 0x40. The sequences drive the in-service set into orders where clearing the wrong in-service bit, or comparing whole vectors where classes are meant, flips `irq`. Acknowledge thresholds are probed exactly at the task priority and one step below it.

// File: rtl/vpu_pkg.sv
// Shared types for the vectored interrupt priority unit.
package vpu_pkg;

    // Trigger type carried with every posted vector.
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Outcome of one acknowledge cycle.
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_GRANT = 2'd1,
        ACK_SPUR  = 2'd2
    } ack_kind_e;

endpackage

// File: rtl/vpu_top_find.sv
// Highest-set-bit finder.
// Does: returns the index of the most significant set bit of a 2**IDX_W
// wide vector, plus a flag telling whether any bit is set.
// Assumes: IDX_W small enough for a linear scan (256 bits by default).
module vpu_top_find #(
    parameter int IDX_W = 8
) (
    input  logic [(1<<IDX_W)-1:0] bits,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);
    localparam int N = 1 << IDX_W;

    // Scan upward so the last set bit seen, the highest, wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpu_bitvec_regs.sv
// Pending / in-service / trigger-type bit vectors.
// Does: stores one bit per vector in each of three vectors and applies
// the post, grant and retire updates of one cycle together.
// Assumes: grant and retire indices are valid when their strobes are high;
// a post on the same vector as a grant leaves the pending bit set.
module vpu_bitvec_regs #(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post,
    input  logic [IDX_W-1:0]      post_idx,
    input  logic                  post_level,
    input  logic                  grant,
    input  logic [IDX_W-1:0]      grant_idx,
    input  logic                  retire,
    input  logic [IDX_W-1:0]      retire_idx,
    output logic [(1<<IDX_W)-1:0] pend,
    output logic [(1<<IDX_W)-1:0] insvc,
    output logic [(1<<IDX_W)-1:0] trig
);
    localparam int N = 1 << IDX_W;

    logic [N-1:0] post_mask, grant_mask, retire_mask;

    // Decode the three strobes into one-hot masks.
    always_comb begin
        post_mask   = '0;
        grant_mask  = '0;
        retire_mask = '0;
        if (post)   post_mask[post_idx]     = 1'b1;
        if (grant)  grant_mask[grant_idx]   = 1'b1;
        if (retire) retire_mask[retire_idx] = 1'b1;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            // Per-vector state update: a post beats a grant on the pending bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[g]  <= 1'b0;
                    insvc[g] <= 1'b0;
                    trig[g]  <= 1'b0;
                end else begin
                    pend[g]  <= (pend[g] & ~grant_mask[g]) | post_mask[g];
                    insvc[g] <= (insvc[g] & ~retire_mask[g]) | grant_mask[g];
                    if (post_mask[g]) trig[g] <= post_level;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vpu_prio_ctrl.sv
// Priority decision logic.
// Does: forms the processor priority and the interrupt line, and decides
// whether an acknowledge is granted or answered with the spurious vector.
// Assumes: priority classes are the bits above CLS_LSB of a vector number.
module vpu_prio_ctrl
    import vpu_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int CLS_LSB = 4
) (
    input  logic             pend_found,
    input  logic [IDX_W-1:0] pend_top,
    input  logic             insvc_found,
    input  logic [IDX_W-1:0] insvc_top,
    input  logic [IDX_W-1:0] tpr,
    input  logic             enable,
    input  logic             ack,
    output logic [IDX_W-1:0] ppr,
    output logic             irq,
    output ack_kind_e        ack_kind
);
    localparam int CLS_W = IDX_W - CLS_LSB;

    logic [CLS_W-1:0] tpr_cls, insvc_cls, pend_cls, ppr_cls;

    // Split vectors into priority classes; no in-service vector means class 0.
    always_comb begin
        tpr_cls   = tpr[IDX_W-1:CLS_LSB];
        insvc_cls = insvc_found ? insvc_top[IDX_W-1:CLS_LSB] : '0;
        pend_cls  = pend_top[IDX_W-1:CLS_LSB];
    end

    // Processor priority: task priority unless in-service work outranks it.
    always_comb begin
        if (tpr_cls >= insvc_cls) ppr = tpr;
        else                      ppr = {insvc_cls, {CLS_LSB{1'b0}}};
        ppr_cls = ppr[IDX_W-1:CLS_LSB];
    end

    // Interrupt line: enabled, pending, and class above processor priority.
    always_comb begin
        irq = enable && pend_found && ((ppr == '0) || (pend_cls > ppr_cls));
    end

    // Acknowledge outcome against the full task priority value.
    always_comb begin
        if (!ack)
            ack_kind = ACK_IDLE;
        else if (!pend_found || ((tpr != '0) && (pend_top <= tpr)))
            ack_kind = ACK_SPUR;
        else
            ack_kind = ACK_GRANT;
    end
endmodule

// File: rtl/vec_prio_unit.sv
// Vectored interrupt priority unit, top level.
// Does: holds task priority and spurious-vector registers, wires the bit
// vectors, the two highest-bit finders and the decision logic, and
// registers the acknowledge result for one cycle.
// Assumes: a full task-priority write wins over a short one in the same
// cycle; all strobes are single-cycle pulses in the clk domain.
module vec_prio_unit
    import vpu_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int CLS_LSB = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [IDX_W-1:0]         req_vector,
    input  logic                     req_level,
    input  logic                     tpr_wr,
    input  logic [IDX_W-1:0]         tpr_wdata,
    input  logic                     tpr_short_wr,
    input  logic [IDX_W-CLS_LSB-1:0] tpr_short_wdata,
    output logic [IDX_W-CLS_LSB-1:0] tpr_short_rd,
    input  logic                     svr_wr,
    input  logic [IDX_W:0]           svr_wdata,
    input  logic                     ack,
    input  logic                     eoi,
    output logic                     irq,
    output logic                     ack_valid,
    output logic [IDX_W-1:0]         ack_vector,
    output logic                     ack_level
);
    localparam int N = 1 << IDX_W;

    logic [IDX_W-1:0] tpr_q;
    logic [IDX_W:0]   svr_q;
    logic [N-1:0]     irr_q, isr_q, tmr_q;
    logic             irr_any, isr_any;
    logic [IDX_W-1:0] irr_top, isr_top, ppr;
    ack_kind_e        ack_kind;
    logic             grant, retire;

    // Task priority register with full and class-only write paths.
    always_ff @(posedge clk) begin
        if (!rst_n)            tpr_q <= '0;
        else if (tpr_wr)       tpr_q <= tpr_wdata;
        else if (tpr_short_wr) tpr_q <= {tpr_short_wdata, {CLS_LSB{1'b0}}};
    end

    // Spurious-vector register; reset value keeps the unit disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      svr_q <= {1'b0, {IDX_W{1'b1}}};
        else if (svr_wr) svr_q <= svr_wdata;
    end

    assign tpr_short_rd = tpr_q[IDX_W-1:CLS_LSB];

    vpu_top_find #(.IDX_W(IDX_W)) u_find_irr (
        .bits (irr_q),
        .found(irr_any),
        .idx  (irr_top)
    );

    vpu_top_find #(.IDX_W(IDX_W)) u_find_isr (
        .bits (isr_q),
        .found(isr_any),
        .idx  (isr_top)
    );

    vpu_prio_ctrl #(.IDX_W(IDX_W), .CLS_LSB(CLS_LSB)) u_ctrl (
        .pend_found (irr_any),
        .pend_top   (irr_top),
        .insvc_found(isr_any),
        .insvc_top  (isr_top),
        .tpr        (tpr_q),
        .enable     (svr_q[IDX_W]),
        .ack        (ack),
        .ppr        (ppr),
        .irq        (irq),
        .ack_kind   (ack_kind)
    );

    assign grant  = (ack_kind == ACK_GRANT);
    assign retire = eoi && isr_any;

    vpu_bitvec_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (req_valid),
        .post_idx  (req_vector),
        .post_level(req_level),
        .grant     (grant),
        .grant_idx (irr_top),
        .retire    (retire),
        .retire_idx(isr_top),
        .pend      (irr_q),
        .insvc     (isr_q),
        .trig      (tmr_q)
    );

    // Acknowledge result register: granted vector or spurious vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
            ack_level  <= 1'b0;
        end else begin
            ack_valid <= (ack_kind != ACK_IDLE);
            if (ack_kind == ACK_GRANT) begin
                ack_vector <= irr_top;
                ack_level  <= tmr_q[irr_top];
            end else if (ack_kind == ACK_SPUR) begin
                ack_vector <= svr_q[IDX_W-1:0];
                ack_level  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vpu_checker.sv
// Property checker for vec_prio_unit, attached through bind.
// Does: relates strobes, stored state and outputs across clock edges.
// Assumes: connected to the top's internal state by name.
module vpu_checker #(
    parameter int IDX_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ack,
    input logic                  eoi,
    input logic                  req_valid,
    input logic                  irq,
    input logic                  ack_valid,
    input logic [IDX_W-1:0]      ack_vector,
    input logic [IDX_W-1:0]      tpr_q,
    input logic [IDX_W:0]        svr_q,
    input logic [(1<<IDX_W)-1:0] irr_q,
    input logic [(1<<IDX_W)-1:0] isr_q
);
    logic [IDX_W-1:0] pend_hi;

    // Independent highest-pending index for the refusal check.
    always_comb begin
        pend_hi = '0;
        for (int i = 0; i < (1 << IDX_W); i++)
            if (irr_q[i]) pend_hi = IDX_W'(i);
    end

    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> svr_q[IDX_W]);

    a_r7_ack_returns_next: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_valid);

    a_r7_no_ack_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_valid);

    a_r9_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && (isr_q != '0)) |=>
        ($countones(isr_q) == $past($countones(isr_q)) - 1));

    a_r6_refusal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && !req_valid &&
         ((irr_q == '0) || ((tpr_q != '0) && (pend_hi <= tpr_q)))) |=>
        ($stable(irr_q) && $stable(isr_q) &&
         ack_vector == $past(svr_q[IDX_W-1:0])));

    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !ack_valid));
endmodule

bind vec_prio_unit vpu_checker #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .eoi       (eoi),
    .req_valid (req_valid),
    .irq       (irq),
    .ack_valid (ack_valid),
    .ack_vector(ack_vector),
    .tpr_q     (tpr_q),
    .svr_q     (svr_q),
    .irr_q     (irr_q),
    .isr_q     (isr_q)
);

// File: tb/vec_prio_unit_tb_top.sv
module vec_prio_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic       req_level = 1'b0;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       tpr_short_wr = 1'b0;
    logic [3:0] tpr_short_wdata = '0;
    logic [3:0] tpr_short_rd;
    logic       svr_wr = 1'b0;
    logic [8:0] svr_wdata = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq;
    logic       ack_valid;
    logic [7:0] ack_vector;
    logic       ack_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    vec_prio_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .tpr_short_wr(tpr_short_wr), .tpr_short_wdata(tpr_short_wdata),
        .tpr_short_rd(tpr_short_rd),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata),
        .ack(ack), .eoi(eoi), .irq(irq),
        .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_level(ack_level)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected result per acknowledge response.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7: actual unexpected response %0h expected none", ack_vector);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({ack_level, ack_vector} !== e) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", t, {ack_level, ack_vector}, e);
                end
            end
        end
    end

    // Lower all strobes after one cycle and wait until the results are visible.
    task automatic settle();
        @(negedge clk);
        req_valid = 0; tpr_wr = 0; tpr_short_wr = 0; svr_wr = 0; ack = 0; eoi = 0;
    endtask

    task automatic post(logic [7:0] v, logic lvl);
        req_valid = 1; req_vector = v; req_level = lvl;
        settle();
    endtask

    task automatic do_ack(logic [7:0] v, logic lvl, string tag);
        exp_q.push_back({lvl, v});
        tag_q.push_back(tag);
        ack = 1;
        settle();
    endtask

    task automatic do_eoi();
        eoi = 1;
        settle();
    endtask

    task automatic set_tpr(logic [7:0] v);
        tpr_wr = 1; tpr_wdata = v;
        settle();
    endtask

    task automatic set_svr(logic [8:0] v);
        svr_wr = 1; svr_wdata = v;
        settle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 irq after reset", irq, 0);
        check("R11 ack_valid after reset", ack_valid, 0);
        check("R11 tpr class after reset", tpr_short_rd, 0);
        do_ack(8'hFF, 0, "R8 R11 empty ack gives reset spurious");

        set_svr(9'h03F);
        post(8'h45, 0);
        check("R3 disabled blocks irq", irq, 0);
        set_svr(9'h13F);
        check("R3 enable raises irq", irq, 1);

        post(8'h90, 1);
        do_ack(8'h90, 1, "R1 R2 R7 highest level vector");
        check("R4 R5 class 4 under in-service 0x90", irq, 0);
        do_eoi();
        check("R9 retire reopens irq", irq, 1);

        do_ack(8'h45, 0, "R2 R7 edge vector");
        check("R7 nothing pending", irq, 0);
        post(8'h47, 0);
        check("R4 equal class blocked", irq, 0);
        post(8'h62, 0);
        check("R4 higher class raises", irq, 1);
        do_ack(8'h62, 0, "R1 R7 0x62 over 0x47");
        post(8'h58, 0);
        check("R5 in-service 0x62 blocks 0x58", irq, 0);
        do_eoi();
        check("R9 highest in-service retired", irq, 1);

        tpr_short_wr = 1; tpr_short_wdata = 4'h5;
        settle();
        check("R10 short readback", tpr_short_rd, 4'h5);
        check("R5 R10 tpr 0x50 blocks 0x58", irq, 0);

        set_tpr(8'h58);
        do_ack(8'h3F, 0, "R6 top equal to tpr refused");
        set_tpr(8'h00);
        check("R6 refusal left pending intact", irq, 1);
        set_tpr(8'h57);
        do_ack(8'h58, 0, "R6 top just above tpr granted");
        set_tpr(8'h00);
        do_eoi();
        do_eoi();
        do_eoi();
        check("R9 extra retire harmless", irq, 1);
        do_ack(8'h47, 0, "R1 R9 remaining vector");
        do_eoi();

        post(8'h05, 0);
        check("R4 zero priority admits class 0", irq, 1);
        post(8'hFF, 1);
        post(8'h00, 0);
        do_ack(8'hFF, 1, "R1 top vector 255");
        do_ack(8'h05, 0, "R1 middle vector");
        do_ack(8'h00, 0, "R1 bottom vector 0");
        do_eoi();
        do_eoi();
        do_eoi();
        do_ack(8'h3F, 0, "R8 nothing pending");

        post(8'h30, 1);
        post(8'h30, 0);
        do_ack(8'h30, 0, "R2 newest trigger type");
        do_eoi();

        post(8'h70, 0);
        check("R3 pending raises", irq, 1);
        set_svr(9'h0AA);
        check("R3 disable drops irq", irq, 0);
        set_svr(9'h13F);
        check("R3 re-enable", irq, 1);

        exp_q.push_back({1'b0, 8'h70});
        tag_q.push_back("R12 ack uses old state");
        ack = 1; req_valid = 1; req_vector = 8'h80; req_level = 1;
        settle();
        do_ack(8'h80, 1, "R12 same-cycle post kept");
        do_eoi();
        do_eoi();

        repeat (3) @(negedge clk);
        check("R7 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule